// File: doc/BRIEF.md
# Ethernet Receive Frame Validator

This block sits after a byte-wide receive path from an Ethernet PHY. It looks at one frame at a time. It waits for a run of preamble bytes and the start-of-frame delimiter, then forwards every frame byte to a downstream consumer, from the destination address through the frame check sequence, with a valid strobe. While the frame arrives it counts the bytes, runs a CRC-32 over them and keeps the destination address and the type/length field.

A frame can go bad while it is still arriving. This happens when the PHY flags a receive error, or when the frame runs past the permitted length. In that case the block raises a one-cycle abort and forwards nothing more of that frame. When the data-valid input drops, the block issues one done pulse with a good/bad verdict, so the consumer can keep or release its buffer. In the same cycle it pulses one strobe per error class, which feeds external statistics counters. The captured destination address is offered to a separate address filter. A jumbo input raises the length ceiling from 1518 bytes to 10240 bytes.

Top module: `eth_rx_validator`

## Requirements
- R1: A frame starts after one or more 0x55 bytes followed by 0xD5 while `rx_dv` is high. If any other byte appears in the preamble, the rest of that burst is ignored: no byte is forwarded and no done pulse is issued.
- R2: Every frame byte after the delimiter, up to and including the four FCS bytes, appears on `fwd_data` with `fwd_vld` high, one cycle after it is received, unless the frame has been aborted.
- R3: `done` pulses one cycle after the first cycle in which `rx_dv` is low following a frame. `good` is 1 with it only if all of the following hold: the FCS is correct, the length (address through FCS) lies between 64 and the ceiling, no `rx_er` was seen, and there is no length-field mismatch.
- R4: Suppose the received byte is number ceiling+1, or `rx_er` is high with a frame byte. Then `abort` pulses once, in the cycle in which that byte would have been forwarded. That byte and all later bytes of the frame are not forwarded.
- R5: The length ceiling is 1518 bytes. It is 10240 bytes when `jumbo_en` is high in the delimiter cycle.
- R6: The first six frame bytes are captured into `dst_addr`, with the first byte in bits [7:0] (its bit 0 is the group bit). `dst_vld` pulses one cycle after the sixth byte.
- R7: The FCS is CRC-32 with polynomial 0x04C11DB7, bit-reflected, with initial value all ones, sent as the complemented remainder with the low byte first. `stat[1]` (FCS error) is set when the check fails, the frame is within the ceiling and there is no dribble nibble.
- R8: `stat[0]` (alignment) is set when `rx_dribble` is high in the end cycle, the check fails and the frame is within the ceiling. A dribble nibble alone, with a correct FCS, does not make the frame bad.
- R9: `stat[2]` (short) is set when the frame has fewer than 64 bytes.
- R10: For a frame over the ceiling, `stat[3]` (long) is set if the FCS is correct, and `stat[4]` (jabber) is set if it is not. The two are never set together.
- R11: `stat[5]` (symbol error) is set when `rx_er` was high with any frame byte.
- R12: `stat[6]` (length mismatch) is set when the frame is within the ceiling, has at least 18 bytes, and its type/length field (byte 12 high, byte 13 low) lies between 46 and 1500 and differs from the length minus 18.
- R13: `stat` bits are only ever high in the `done` cycle. When `good` is 1, `stat` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_dv | input | 1 | Receive data valid from the PHY |
| rx_er | input | 1 | Receive error from the PHY |
| rxd | input | 8 | Receive byte |
| rx_dribble | input | 1 | Frame ended on a non-byte boundary; sampled in the end cycle |
| jumbo_en | input | 1 | Raises the length ceiling; sampled at the delimiter |
| fwd_data | output | 8 | Forwarded frame byte |
| fwd_vld | output | 1 | `fwd_data` holds a frame byte |
| abort | output | 1 | One-cycle pulse: frame found bad mid-reception |
| done | output | 1 | One-cycle end-of-frame pulse |
| good | output | 1 | Verdict, valid with `done` |
| stat | output | 7 | Error-class strobes, valid with `done` |
| dst_addr | output | 48 | Captured destination address |
| dst_vld | output | 1 | Pulse: `dst_addr` complete |

## Verification
The cases hardest to reach from the ports are those at and past the ceiling. There, the byte counter saturates, abort must fall on exactly byte ceiling+1, and the long/jabber split depends on a CRC that kept running after forwarding stopped. The bench builds frames in memory with a payload pattern and an FCS it computes itself. It then drives frames of exactly the ceiling and one byte more, in both normal and jumbo modes, and corrupts the last FCS byte to move a frame from long to jabber. A receive error placed on a chosen byte index confirms that the forwarded byte count stops exactly there.

// File: rtl/eth_rxv_pkg.sv
package eth_rxv_pkg;
  typedef enum logic [1:0] {S_IDLE, S_PRE, S_DATA, S_SKIP} rxv_state_t;

  localparam int ST_ALIGN = 0;
  localparam int ST_FCS   = 1;
  localparam int ST_SHORT = 2;
  localparam int ST_LONG  = 3;
  localparam int ST_JAB   = 4;
  localparam int ST_SYM   = 5;
  localparam int ST_LEN   = 6;
  localparam int ST_N     = 7;

  localparam logic [7:0]  PRE_BYTE     = 8'h55;
  localparam logic [7:0]  SFD_BYTE     = 8'hD5;
  localparam logic [31:0] CRC_POLY_R   = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE  = 32'hDEBB20E3;

  // one byte of the reflected CRC-32, data bits consumed LSB first
  function automatic logic [31:0] crc32_step(logic [31:0] c, logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/eth_rxv_crc.sv
module eth_rxv_crc
  import eth_rxv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       en,
  input  logic [7:0] din,
  output logic       crc_ok
);
  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (init)    crc_d = '1;
    else if (en) crc_d = crc32_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          crc_q <= '1;
    else if (init || en) crc_q <= crc_d;
  end

  assign crc_ok = (crc_q == CRC_RESIDUE);
endmodule

// File: rtl/eth_rxv_ctrl.sv
module eth_rxv_ctrl
  import eth_rxv_pkg::*;
#(
  parameter int MAX_STD   = 1518,
  parameter int MAX_JUMBO = 10240,
  parameter int CW        = $clog2(MAX_JUMBO + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_dv,
  input  logic          rx_er,
  input  logic [7:0]    rxd,
  input  logic          jumbo_en,
  output logic          sof,
  output logic          byte_en,
  output logic          eof,
  output logic [CW-1:0] cnt_q,
  output logic          too_long,
  output logic          sym_q,
  output logic          aborted_q,
  output logic          abort_o,
  output logic          fwd_vld_o,
  output logic [7:0]    fwd_data_o
);
  localparam logic [CW-1:0] LIM_STD = CW'(MAX_STD);
  localparam logic [CW-1:0] LIM_JMB = CW'(MAX_JUMBO);
  localparam logic [CW-1:0] CNT_SAT = CW'(MAX_JUMBO + 1);

  rxv_state_t    state_q, state_d;
  logic          jumbo_q;
  logic [CW-1:0] cnt_d, lim;
  logic          bad_now, abort_d, fwd_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (rx_dv) state_d = (rxd == PRE_BYTE) ? S_PRE : S_SKIP;
      S_PRE: begin
        if (!rx_dv)               state_d = S_IDLE;
        else if (rxd == SFD_BYTE) state_d = S_DATA;
        else if (rxd != PRE_BYTE) state_d = S_SKIP;
      end
      S_DATA: if (!rx_dv) state_d = S_IDLE;
      default: if (!rx_dv) state_d = S_IDLE;
    endcase
  end

  assign sof      = (state_q == S_PRE) && rx_dv && (rxd == SFD_BYTE);
  assign byte_en  = (state_q == S_DATA) && rx_dv;
  assign eof      = (state_q == S_DATA) && !rx_dv;
  assign lim      = jumbo_q ? LIM_JMB : LIM_STD;
  assign too_long = cnt_q > lim;
  assign bad_now  = byte_en && (rx_er || (cnt_q >= lim));
  assign abort_d  = bad_now && !aborted_q;
  assign fwd_d    = byte_en && !bad_now && !aborted_q;

  always_comb begin
    cnt_d = cnt_q;
    if (sof)                            cnt_d = '0;
    else if (byte_en && cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      jumbo_q    <= 1'b0;
      aborted_q  <= 1'b0;
      sym_q      <= 1'b0;
      abort_o    <= 1'b0;
      fwd_vld_o  <= 1'b0;
      fwd_data_o <= '0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      abort_o   <= abort_d;
      fwd_vld_o <= fwd_d;
      if (sof) begin
        jumbo_q   <= jumbo_en;
        aborted_q <= 1'b0;
        sym_q     <= 1'b0;
      end else begin
        if (bad_now)          aborted_q <= 1'b1;
        if (byte_en && rx_er) sym_q     <= 1'b1;
      end
      if (byte_en) fwd_data_o <= rxd;
    end
  end

  a_r4_no_fwd_after_abort: assert property (@(posedge clk) disable iff (!rst_n)
    aborted_q |-> !fwd_vld_o);
  a_r4_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_SAT);
endmodule

// File: rtl/eth_rxv_capture.sv
module eth_rxv_capture #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_en,
  input  logic [CW-1:0] cnt,
  input  logic [7:0]    din,
  output logic [47:0]   dst_o,
  output logic          dst_vld_o,
  output logic [15:0]   typelen_o
);
  localparam int DA_BYTES = 6;
  localparam int TL_HI    = 12;

  for (genvar g = 0; g < DA_BYTES; g++) begin : g_da
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          dst_o[8*g +: 8] <= '0;
      else if (byte_en && cnt == CW'(g))   dst_o[8*g +: 8] <= din;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_tl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              typelen_o[8*(1-h) +: 8] <= '0;
      else if (byte_en && cnt == CW'(TL_HI + h)) typelen_o[8*(1-h) +: 8] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dst_vld_o <= 1'b0;
    else        dst_vld_o <= byte_en && (cnt == CW'(DA_BYTES - 1));
  end

  a_r6_dst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dst_vld_o |=> !dst_vld_o);
endmodule

// File: rtl/eth_rxv_verdict.sv
module eth_rxv_verdict
  import eth_rxv_pkg::*;
#(
  parameter int CW           = 14,
  parameter int MIN_LEN      = 64,
  parameter int MIN_PAYLOAD  = 46,
  parameter int MAX_LENFIELD = 1500
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eof,
  input  logic            dribble,
  input  logic            crc_ok,
  input  logic            too_long,
  input  logic            aborted,
  input  logic            sym,
  input  logic [CW-1:0]   cnt,
  input  logic [15:0]     typelen,
  output logic            done_o,
  output logic            good_o,
  output logic [ST_N-1:0] stat_o
);
  localparam int HDR_FCS = 18;

  logic [15:0]     cnt16, pay_len;
  logic            crc_bad, len_mis;
  logic [ST_N-1:0] st;

  assign cnt16   = 16'(cnt);
  assign pay_len = cnt16 - 16'(HDR_FCS);
  assign crc_bad = !crc_ok;
  assign len_mis = !too_long && (cnt16 >= 16'(HDR_FCS)) &&
                   (typelen <= 16'(MAX_LENFIELD)) && (typelen >= 16'(MIN_PAYLOAD)) &&
                   (typelen != pay_len);

  always_comb begin
    st           = '0;
    st[ST_ALIGN] = !too_long && dribble && crc_bad;
    st[ST_FCS]   = !too_long && !dribble && crc_bad;
    st[ST_SHORT] = cnt16 < 16'(MIN_LEN);
    st[ST_LONG]  = too_long && !crc_bad;
    st[ST_JAB]   = too_long && crc_bad;
    st[ST_SYM]   = sym;
    st[ST_LEN]   = len_mis;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      good_o <= 1'b0;
      stat_o <= '0;
    end else begin
      done_o <= eof;
      good_o <= eof && !aborted && crc_ok && !st[ST_SHORT] && !len_mis;
      stat_o <= eof ? st : '0;
    end
  end

  a_r13_stat_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_o) |-> done_o);
  a_r13_good_clean: assert property (@(posedge clk) disable iff (!rst_n)
    good_o |-> (stat_o == '0));
  a_r10_long_jab_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_o[ST_LONG] && stat_o[ST_JAB]));
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/eth_rx_validator.sv
module eth_rx_validator
  import eth_rxv_pkg::*;
#(
  parameter int MAX_STD   = 1518,
  parameter int MAX_JUMBO = 10240,
  parameter int MIN_LEN   = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_dv,
  input  logic            rx_er,
  input  logic [7:0]      rxd,
  input  logic            rx_dribble,
  input  logic            jumbo_en,
  output logic [7:0]      fwd_data,
  output logic            fwd_vld,
  output logic            abort,
  output logic            done,
  output logic            good,
  output logic [ST_N-1:0] stat,
  output logic [47:0]     dst_addr,
  output logic            dst_vld
);
  localparam int CW = $clog2(MAX_JUMBO + 2);

  logic          sof, byte_en, eof, too_long, sym, aborted, crc_ok;
  logic [CW-1:0] cnt;
  logic [15:0]   typelen;

  eth_rxv_ctrl #(.MAX_STD(MAX_STD), .MAX_JUMBO(MAX_JUMBO), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd),
    .jumbo_en(jumbo_en), .sof(sof), .byte_en(byte_en), .eof(eof), .cnt_q(cnt),
    .too_long(too_long), .sym_q(sym), .aborted_q(aborted), .abort_o(abort),
    .fwd_vld_o(fwd_vld), .fwd_data_o(fwd_data));

  eth_rxv_crc u_crc (
    .clk(clk), .rst_n(rst_n), .init(sof), .en(byte_en), .din(rxd), .crc_ok(crc_ok));

  eth_rxv_capture #(.CW(CW)) u_cap (
    .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .cnt(cnt), .din(rxd),
    .dst_o(dst_addr), .dst_vld_o(dst_vld), .typelen_o(typelen));

  eth_rxv_verdict #(.CW(CW), .MIN_LEN(MIN_LEN)) u_verdict (
    .clk(clk), .rst_n(rst_n), .eof(eof), .dribble(rx_dribble), .crc_ok(crc_ok),
    .too_long(too_long), .aborted(aborted), .sym(sym), .cnt(cnt), .typelen(typelen),
    .done_o(done), .good_o(good), .stat_o(stat));
endmodule

// File: tb/eth_rx_validator_test.sv
module eth_rx_validator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_dv = 1'b0, rx_er = 1'b0, rx_dribble = 1'b0, jumbo_en = 1'b0;
  logic [7:0]  rxd = 8'h00;
  logic [7:0]  fwd_data;
  logic        fwd_vld, abort, done, good, dst_vld;
  logic [6:0]  stat;
  logic [47:0] dst_addr;

  eth_rx_validator uut (
    .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd),
    .rx_dribble(rx_dribble), .jumbo_en(jumbo_en), .fwd_data(fwd_data),
    .fwd_vld(fwd_vld), .abort(abort), .done(done), .good(good), .stat(stat),
    .dst_addr(dst_addr), .dst_vld(dst_vld));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;
  logic [7:0] fr [0:10299];
  int n;

  // port monitor
  int fwd_cnt = 0, abort_cnt = 0, done_cnt = 0, fwd_mis = 0;
  logic       m_good;
  logic [6:0] m_stat;
  logic [47:0] m_dst;
  logic       e0, e1;

  always @(negedge clk) if (rst_n) begin
    if (fwd_vld) begin
      if (fwd_data !== fr[fwd_cnt % 10300]) fwd_mis++;
      fwd_cnt++;
    end
    if (abort) abort_cnt++;
    if (done) begin done_cnt++; m_good = good; m_stat = stat; end
    if (dst_vld) m_dst = dst_addr;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=%0d expected<%0d cycles", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(int len);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++) begin
      c = c ^ {24'h0, fr[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic build(int len, logic [15:0] tl, bit grp);
    logic [31:0] f;
    n = len;
    for (int i = 0; i < len - 4; i++) fr[i] = 8'((i * 7) + 3);
    fr[0] = grp ? 8'h01 : 8'h02;
    for (int i = 1; i < 6; i++) fr[i] = 8'h10 + 8'(i);
    fr[12] = tl[15:8];
    fr[13] = tl[7:0];
    f = ref_crc(len - 4);
    for (int k = 0; k < 4; k++) fr[len - 4 + k] = f[8*k +: 8];
  endtask

  task automatic drive(logic [7:0] b, logic er);
    rx_dv = 1'b1; rxd = b; rx_er = er;
    @(posedge clk); #1;
  endtask

  task automatic send(int pre_n, bit drib, int er_at);
    fwd_cnt = fwd_cnt; // monitor-owned; snapshots taken by callers
    for (int p = 0; p < pre_n; p++) drive(8'h55, 1'b0);
    drive(8'hD5, 1'b0);
    for (int i = 0; i < n; i++) drive(fr[i], i == er_at);
    rx_dv = 1'b0; rx_er = 1'b0; rxd = 8'h00; rx_dribble = drib;
    @(negedge clk) e0 = done;
    @(posedge clk); #1 rx_dribble = 1'b0;
    @(negedge clk) e1 = done;
    repeat (3) @(posedge clk);
    #1;
  endtask

  // runs one frame and checks its outcome
  task automatic frame_case(string req, int len, logic [15:0] tl, bit corrupt, bit drib,
                            int er_at, bit exp_good, logic [6:0] exp_stat, int exp_fwd,
                            int exp_abort);
    int f0, a0, d0, m0;
    build(len, tl, 1'b0);
    if (corrupt) fr[len - 1] = fr[len - 1] ^ 8'h5A;
    f0 = fwd_cnt; a0 = abort_cnt; d0 = done_cnt; m0 = fwd_mis;
    fwd_cnt = 0;
    send(3, drib, er_at);
    check(done_cnt - d0 == 1, req, "done pulses", done_cnt - d0, 1);
    check(m_good == exp_good, req, "good", m_good, exp_good);
    check(m_stat == exp_stat, req, "stat", m_stat, exp_stat);
    check(fwd_cnt == exp_fwd, req, "forwarded bytes", fwd_cnt, exp_fwd);
    check(fwd_mis == m0, req, "forwarded data", fwd_mis - m0, 0);
    check(abort_cnt - a0 == exp_abort, req, "abort pulses", abort_cnt - a0, exp_abort);
    fwd_cnt = f0;
  endtask

  task automatic t_reset;
    check(!fwd_vld && !abort && !done && !good && stat == 0 && !dst_vld, "R3",
          "reset outputs", {fwd_vld, abort, done, good, stat, dst_vld}, 0);
  endtask

  task automatic t_good_min;
    // R1 R2 R3 R6: 64-byte good frame, group destination
    int d0;
    build(64, 16'd46, 1'b1);
    d0 = done_cnt; fwd_cnt = 0;
    send(7, 1'b0, -1);
    check(e0 == 0 && e1 == 1, "R3", "done timing", {e0, e1}, 2'b01);
    check(m_good == 1, "R3", "good", m_good, 1);
    check(m_stat == 0, "R13", "stat clean", m_stat, 0);
    check(fwd_cnt == 64, "R2", "forwarded bytes", fwd_cnt, 64);
    check(m_dst == {fr[5], fr[4], fr[3], fr[2], fr[1], fr[0]} && m_dst[0], "R6",
          "dst", m_dst, {fr[5], fr[4], fr[3], fr[2], fr[1], fr[0]});
    check(done_cnt - d0 == 1, "R1", "one verdict", done_cnt - d0, 1);
  endtask

  task automatic t_bad_preamble;
    // R1: stray byte inside the preamble
    int d0;
    d0 = done_cnt; fwd_cnt = 0;
    drive(8'h55, 0); drive(8'h12, 0); drive(8'hD5, 0);
    for (int i = 0; i < 70; i++) drive(8'(i), 0);
    rx_dv = 1'b0; repeat (4) @(posedge clk); #1;
    check(done_cnt == d0, "R1", "no verdict", done_cnt - d0, 0);
    check(fwd_cnt == 0, "R1", "no forwarding", fwd_cnt, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk) t_reset();
    @(posedge clk); #1;
    t_good_min();
    frame_case("R7",  100, 16'h0800, 1, 0, -1, 0, 7'b0000010, 100, 0);
    frame_case("R9",  40,  16'h0800, 0, 0, -1, 0, 7'b0000100, 40, 0);
    frame_case("R5",  1518, 16'h0800, 0, 0, -1, 1, 7'b0000000, 1518, 0);
    frame_case("R10", 1519, 16'h0800, 0, 0, -1, 0, 7'b0001000, 1518, 1);
    frame_case("R10", 1530, 16'h0800, 1, 0, -1, 0, 7'b0010000, 1518, 1);
    frame_case("R11", 100, 16'h0800, 0, 0, 20, 0, 7'b0100000, 20, 1);
    frame_case("R8",  80,  16'h0800, 1, 1, -1, 0, 7'b0000001, 80, 0);
    frame_case("R8",  80,  16'h0800, 0, 1, -1, 1, 7'b0000000, 80, 0);
    frame_case("R12", 78,  16'd100,  0, 0, -1, 0, 7'b1000000, 78, 0);
    frame_case("R12", 64,  16'd30,   0, 0, -1, 1, 7'b0000000, 64, 0);
    jumbo_en = 1'b1;
    frame_case("R5",  10240, 16'h0800, 0, 0, -1, 1, 7'b0000000, 10240, 0);
    frame_case("R4",  10241, 16'h0800, 0, 0, -1, 0, 7'b0001000, 10240, 1);
    jumbo_en = 1'b0;
    frame_case("R4",  2000, 16'h0800, 0, 0, -1, 0, 7'b0001000, 1518, 1);
    t_bad_preamble();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule